// File: doc/BRIEF.md
# Clocked Slave FIFO Master Sequencer

This block is the master side of a synchronous slave FIFO port. It takes one command at a time: a direction, a FIFO address, a byte count and, for writes, a request to close the packet. It then runs the strobes on the shared bus so that the slave sees a legal single or burst transfer.

Before any strobe, the sequencer holds the address and chip select for a fixed number of setup cycles. On reads it turns on the output enable one cycle before the read strobe, so the word the slave has already fetched is on the bus. It streams one byte per clock while the slave's empty or full flag allows. After a write burst it can send a packet-end pulse. Read bytes leave on an output stream, and write bytes come from an input stream that the block pops once for each accepted write. When a command ends, the block gives a one-cycle done pulse with the number of bytes moved.

Top module: `fifo_master_seq`

## Requirements
- R1: After a command is taken, `busSel` and `busAddr` are driven for `SETUP_CYC` (default 2) cycles with no strobe. `busAddr` stays stable while `busSel` is high. With no flag stall, the first write strobe comes in cycle `SETUP_CYC+1` after the accepting edge, and the first read strobe in cycle `SETUP_CYC+2`.
- R2: On a read command, `busOe` rises in cycle `SETUP_CYC+1`, exactly one cycle before the read strobe can first assert, and it stays high through the whole burst. A write command never asserts `busOe`.
- R3: `busSel` is high in every cycle in which `busRd` or `busWr` is high.
- R4: While `busWr` is high, `busDout` equals `wrData`, and `wrPop` equals `busWr`. Each accepted write edge consumes one source word.
- R5: A command of length L makes exactly L strobe cycles. With no flag stall these cycles are consecutive, so one byte moves per clock, and the strobe drops after the last one. A length of 1 is a single transfer.
- R6: `busRd` is low whenever `busEmpty` is high, and `busWr` is low whenever `busFull` is high. When the flag clears, the transfer resumes with no byte lost or repeated.
- R7: A write command with `cmdPktEnd` set gives a single-cycle `busPktEnd` with `busSel` high, in the cycle right after the last write strobe. A read command ignores `cmdPktEnd`, and no packet-end pulse is produced for it.
- R8: For each accepted read edge, `rdValid` is high in the following cycle, and `rdData` holds the `busDin` word present at that edge.
- R9: `done` pulses for one cycle, in the cycle after the last strobe (or after the packet-end pulse), with `doneCount` equal to the number of bytes moved. `cmdReady` is high only when no command is running.
- R10: After reset, `cmdReady` is high, and all bus strobes, `busOe`, `busSel`, `busPktEnd`, `done` and `rdValid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command offered |
| cmdReady | output | 1 | Sequencer idle, command taken on this edge |
| cmdRead | input | 1 | 1 = read from slave, 0 = write to slave |
| cmdAddr | input | ADDR_W | FIFO select address |
| cmdLen | input | LEN_W | Byte count, nonzero |
| cmdPktEnd | input | 1 | Close the packet after a write |
| wrData | input | DATA_W | Next write byte from the source stream |
| wrPop | output | 1 | Source word consumed at this edge |
| rdData | output | DATA_W | Captured read byte |
| rdValid | output | 1 | `rdData` valid this cycle |
| done | output | 1 | Command finished (one cycle) |
| doneCount | output | LEN_W | Bytes moved by the finished command |
| busAddr | output | ADDR_W | FIFO address to the slave |
| busSel | output | 1 | Chip select, active high |
| busOe | output | 1 | Output enable, active high |
| busRd | output | 1 | Read strobe, active high |
| busWr | output | 1 | Write strobe, active high |
| busPktEnd | output | 1 | Packet commit pulse, active high |
| busDout | output | DATA_W | Write data to the slave |
| busDin | input | DATA_W | Read data from the slave |
| busEmpty | input | 1 | Slave FIFO empty flag, active high |
| busFull | input | 1 | Slave FIFO full flag, active high |

## Verification
The harder overlaps are a flag change landing on the edge that would carry the final byte of a burst, and a stall landing on the first strobe cycle right after the output enable. The bench drives `busEmpty` and `busFull` with a periodic pattern, offset from the command starts, so that across several burst lengths both overlaps occur. It judges them with the scoreboard, which must see every byte exactly once and in order, with the total strobe count and `doneCount` equal to the requested length. A second overlap it watches is the last read capture (`rdValid`) falling in the same cycle as the `done` pulse. Both must be seen there, with neither one hiding the other.

// File: rtl/fms_pkg.sv
package fms_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_OE,
    ST_XFER,
    ST_PKT,
    ST_DONE
  } fmsState_e;

  typedef struct packed {
    logic load;    // latch a new command
    logic accept;  // a strobe is sampled by the slave this edge
  } fmsStrobe_t;
endpackage

// File: rtl/fms_ctrl.sv
module fms_ctrl
  import fms_pkg::*;
#(
  parameter int SETUP_CYC = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic       isRead,
  input  logic       wantPkt,
  input  logic       lastByte,
  input  logic       busEmpty,
  input  logic       busFull,
  output logic       cmdReady,
  output logic       busSel,
  output logic       busOe,
  output logic       busRd,
  output logic       busWr,
  output logic       busPktEnd,
  output logic       done,
  output fmsStrobe_t strobe
);
  localparam int CNT_W = (SETUP_CYC > 1) ? $clog2(SETUP_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETUP_CYC - 1);

  fmsState_e state, stateNext;
  logic [CNT_W-1:0] setupCnt;
  logic inXfer;

  assign inXfer    = (state == ST_XFER);
  assign cmdReady  = (state == ST_IDLE);
  assign busSel    = (state == ST_SETUP) || (state == ST_OE) || inXfer || (state == ST_PKT);
  assign busOe     = isRead && ((state == ST_OE) || inXfer);
  assign busRd     = inXfer && isRead && !busEmpty;
  assign busWr     = inXfer && !isRead && !busFull;
  assign busPktEnd = (state == ST_PKT);
  assign done      = (state == ST_DONE);

  assign strobe.load   = cmdValid && cmdReady;
  assign strobe.accept = busRd || busWr;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (cmdValid) stateNext = ST_SETUP;
      ST_SETUP: if (setupCnt == CNT_LAST) stateNext = isRead ? ST_OE : ST_XFER;
      ST_OE:    stateNext = ST_XFER;
      ST_XFER:  if (strobe.accept && lastByte) stateNext = wantPkt ? ST_PKT : ST_DONE;
      ST_PKT:   stateNext = ST_DONE;
      ST_DONE:  stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      setupCnt <= '0;
    end else begin
      state <= stateNext;
      if (state == ST_SETUP) setupCnt <= setupCnt + 1'b1;
      else                   setupCnt <= '0;
    end
  end

  AST_SEL_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busSel) |=> !(busRd || busWr));  // R1
  AST_SEL_COVERS: assert property (@(posedge clk) disable iff (!rstN)
    (busRd || busWr) |-> busSel);  // R3
  AST_OE_BEFORE_RD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busRd) |-> $past(busOe));  // R2
  AST_NO_RD_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    busEmpty |-> !busRd);  // R6
  AST_NO_WR_FULL: assert property (@(posedge clk) disable iff (!rstN)
    busFull |-> !busWr);  // R6
  AST_BURST_CONT: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busRd) && !$past(lastByte) && !busEmpty) |-> busRd);  // R5
  AST_PKT_AFTER_WR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busPktEnd) |-> $past(busWr));  // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);  // R9
endmodule

// File: rtl/fms_dpath.sv
module fms_dpath
  import fms_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  fmsStrobe_t        strobe,
  input  logic              cmdRead,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [LEN_W-1:0]  cmdLen,
  input  logic              cmdPktEnd,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] busDin,
  input  logic              busSel,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busDout,
  output logic              isRead,
  output logic              wantPkt,
  output logic              lastByte,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic [LEN_W-1:0]  doneCount
);
  logic [LEN_W-1:0] remainQ;
  logic [LEN_W-1:0] movedQ;

  assign busDout   = wrData;
  assign lastByte  = (remainQ == LEN_W'(1));
  assign doneCount = movedQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busAddr <= '0;
      isRead  <= 1'b0;
      wantPkt <= 1'b0;
      remainQ <= '0;
      movedQ  <= '0;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strobe.accept && isRead;
      if (strobe.accept && isRead) rdData <= busDin;
      if (strobe.load) begin
        busAddr <= cmdAddr;
        isRead  <= cmdRead;
        wantPkt <= cmdPktEnd && !cmdRead;
        remainQ <= cmdLen;
        movedQ  <= '0;
      end else if (strobe.accept) begin
        remainQ <= remainQ - 1'b1;
        movedQ  <= movedQ + 1'b1;
      end
    end
  end

  AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |-> (cmdLen != '0));  // R5
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && $past(busSel)) |-> $stable(busAddr));  // R1
  AST_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.accept && isRead) |-> (rdValid && rdData == $past(busDin)));  // R8
endmodule

// File: rtl/fifo_master_seq.sv
module fifo_master_seq
  import fms_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int DATA_W    = 8,
  parameter int LEN_W     = 8,
  parameter int SETUP_CYC = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic              cmdRead,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [LEN_W-1:0]  cmdLen,
  input  logic              cmdPktEnd,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrPop,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              done,
  output logic [LEN_W-1:0]  doneCount,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busSel,
  output logic              busOe,
  output logic              busRd,
  output logic              busWr,
  output logic              busPktEnd,
  output logic [DATA_W-1:0] busDout,
  input  logic [DATA_W-1:0] busDin,
  input  logic              busEmpty,
  input  logic              busFull
);
  fmsStrobe_t strobe;
  logic isRead, wantPkt, lastByte;

  assign wrPop = busWr;

  fms_ctrl #(.SETUP_CYC(SETUP_CYC)) uCtrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .isRead(isRead),
    .wantPkt(wantPkt), .lastByte(lastByte), .busEmpty(busEmpty), .busFull(busFull),
    .cmdReady(cmdReady), .busSel(busSel), .busOe(busOe), .busRd(busRd),
    .busWr(busWr), .busPktEnd(busPktEnd), .done(done), .strobe(strobe)
  );

  fms_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdRead(cmdRead), .cmdAddr(cmdAddr),
    .cmdLen(cmdLen), .cmdPktEnd(cmdPktEnd), .wrData(wrData), .busDin(busDin),
    .busSel(busSel), .busAddr(busAddr), .busDout(busDout), .isRead(isRead),
    .wantPkt(wantPkt), .lastByte(lastByte), .rdData(rdData), .rdValid(rdValid),
    .doneCount(doneCount)
  );

  AST_WR_DATA: assert property (@(posedge clk) disable iff (!rstN)
    busWr |-> (wrPop && busDout == wrData));  // R4
endmodule

// File: tb/fifo_master_seq_test.sv
module fifo_master_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int SETUP_CYC  = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0, cmdReady, cmdRead = 1'b0, cmdPktEnd = 1'b0;
  logic [1:0] cmdAddr = '0;
  logic [7:0] cmdLen = '0;
  logic [7:0] wrData, rdData, busDout, busDin, doneCount;
  logic [1:0] busAddr;
  logic wrPop, rdValid, done, busSel, busOe, busRd, busWr, busPktEnd;
  logic busEmpty = 1'b0, busFull = 1'b0;

  int checks = 0, failures = 0;
  int rdPtr = 0, rdPtrNext = 0;
  logic [7:0] srcVal = 8'h40, srcNext = 8'h40;
  bit stallOn = 1'b0;
  int tick = 0;
  logic [7:0] expRd[$];
  logic [7:0] expWr[$];

  fifo_master_seq #(.SETUP_CYC(SETUP_CYC)) uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdRead(cmdRead), .cmdAddr(cmdAddr), .cmdLen(cmdLen), .cmdPktEnd(cmdPktEnd),
    .wrData(wrData), .wrPop(wrPop), .rdData(rdData), .rdValid(rdValid),
    .done(done), .doneCount(doneCount), .busAddr(busAddr), .busSel(busSel),
    .busOe(busOe), .busRd(busRd), .busWr(busWr), .busPktEnd(busPktEnd),
    .busDout(busDout), .busDin(busDin), .busEmpty(busEmpty), .busFull(busFull)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // slave and source models
  assign busDin = 8'(rdPtr * 7 + 3);
  assign wrData = srcVal;
  always @(posedge clk) begin
    if (busRd) rdPtr <= rdPtr + 1;
    if (wrPop) srcVal <= srcVal + 8'd1;
  end
  always @(posedge clk) begin
    #1;
    tick++;
    busEmpty = stallOn && (tick % 4 == 1);
    busFull  = stallOn && (tick % 3 == 0);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: scoreboard for both directions
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expRd.size() == 0) chk(0, "R8 unexpected read byte", int'(rdData), -1);
      else begin
        logic [7:0] e;
        e = expRd.pop_front();
        chk(rdData == e, "R8/R6 read byte", int'(rdData), int'(e));
      end
    end
    if (rstN && busWr) begin
      if (expWr.size() == 0) chk(0, "R4 unexpected write byte", int'(busDout), -1);
      else begin
        logic [7:0] e;
        e = expWr.pop_front();
        chk(busDout == e && wrPop, "R4/R6 write byte", int'(busDout), int'(e));
      end
    end
  end

  task automatic doCmd(input bit rd, input logic [1:0] a, input int len, input bit pkt);
    int n = 0, first = -1, last = -1, strobes = 0, oeAt = -1, pktCnt = 0, pktAt = -1, doneAt = -1;
    bit addrOk = 1'b1, selOk = 1'b1;
    for (int i = 0; i < len; i++) begin
      if (rd) expRd.push_back(8'((rdPtrNext + i) * 7 + 3));
      else    expWr.push_back(srcNext + 8'(i));
    end
    if (rd) rdPtrNext += len; else srcNext += 8'(len);
    @(negedge clk);
    chk(cmdReady, "R9 ready when idle", int'(cmdReady), 1);
    cmdValid = 1'b1; cmdRead = rd; cmdAddr = a; cmdLen = 8'(len); cmdPktEnd = pkt;
    @(posedge clk); #1;
    cmdValid = 1'b0;
    while (doneAt < 0 && n < 2000) begin
      @(negedge clk);
      n++;
      if (busSel && busAddr != a) addrOk = 1'b0;
      if ((busRd || busWr) && !busSel) selOk = 1'b0;
      if (busRd || busWr) begin
        if (first < 0) first = n;
        last = n;
        strobes++;
      end
      if (busOe && oeAt < 0) oeAt = n;
      if (busPktEnd) begin pktCnt++; pktAt = n; end
      if (done) begin
        doneAt = n;
        chk(doneCount == 8'(len), "R9 doneCount", int'(doneCount), len);
      end
    end
    chk(doneAt > 0, "R9 command finished", doneAt, 1);
    chk(strobes == len, "R5 strobe count", strobes, len);
    chk(addrOk, "R1 address held", int'(addrOk), 1);
    chk(selOk, "R3 select with strobe", int'(selOk), 1);
    if (!stallOn) begin
      chk(first == (rd ? SETUP_CYC + 2 : SETUP_CYC + 1), "R1 first strobe cycle", first,
          rd ? SETUP_CYC + 2 : SETUP_CYC + 1);
      chk(last - first + 1 == len, "R5 burst consecutive", last - first + 1, len);
    end
    chk(oeAt == (rd ? SETUP_CYC + 1 : -1), "R2 output enable timing", oeAt,
        rd ? SETUP_CYC + 1 : -1);
    if (pkt && !rd) begin
      chk(pktCnt == 1 && pktAt == last + 1, "R7 packet end after last write", pktAt, last + 1);
      chk(doneAt == pktAt + 1, "R9 done after packet end", doneAt, pktAt + 1);
    end else begin
      chk(pktCnt == 0, "R7 no packet end", pktCnt, 0);
      chk(doneAt == last + 1, "R9 done after last strobe", doneAt, last + 1);
    end
    @(negedge clk);
    chk(!done, "R9 done single cycle", int'(done), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    chk(0, "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk(cmdReady, "R10 ready after reset", int'(cmdReady), 1);
    chk(!busSel && !busOe && !busPktEnd, "R10 bus idle", int'({busSel, busOe, busPktEnd}), 0);
    chk(!busRd && !busWr, "R10 no strobe", int'({busRd, busWr}), 0);
    chk(!done && !rdValid, "R10 no done or data", int'({done, rdValid}), 0);

    doCmd(1'b0, 2'd2, 1, 1'b0);   // single write
    doCmd(1'b1, 2'd0, 1, 1'b0);   // single read
    doCmd(1'b0, 2'd1, 1, 1'b0);   // single write then three-byte burst closed by packet end
    doCmd(1'b0, 2'd1, 3, 1'b1);
    doCmd(1'b1, 2'd3, 8, 1'b0);   // read burst
    doCmd(1'b1, 2'd2, 4, 1'b1);   // R7: packet request ignored on read

    stallOn = 1'b1;
    doCmd(1'b1, 2'd0, 12, 1'b0);  // R6 read with empty stalls
    doCmd(1'b0, 2'd3, 10, 1'b1);  // R6 write with full stalls
    doCmd(1'b1, 2'd1, 5, 1'b0);
    doCmd(1'b0, 2'd2, 7, 1'b0);
    stallOn = 1'b0;

    repeat (3) @(negedge clk);
    chk(expRd.size() == 0, "R6 no read byte lost", expRd.size(), 0);
    chk(expWr.size() == 0, "R6 no write byte lost", expWr.size(), 0);
    chk(rdPtr == rdPtrNext, "R6 slave reads exact", rdPtr, rdPtrNext);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule